// File: doc/BRIEF.md
# Multi-Ratio Clock Divider with Sync Detection

This block is the divider network that sits behind a clock multiplier. A single fast clock stands in for the oscillator. From it the block derives three output banks (A, B and C), an auxiliary output D and a separate feedback output. A 4-bit ratio code sets the divide value of each bank, and a 3-bit code sets the feedback divide. All dividers share one phase origin, so banks with non-binary relationships such as 3:2 or 4:3 keep a fixed alignment. A coincidence flag marks the moments when banks A and C start a new period together.

For board bring-up, a bypass mode replaces every fast-clock step with a rising edge of a slow test clock. That test clock is synchronised into the fast domain and still passes through the dividers, so a single output transition can take several test-clock edges. The configuration inputs are captured only while the synchronous realign input is high. That same pulse returns every divider to a common phase, so a new setting can never take effect part-way through a period.

Top module: `ratio_clk_divider`

## Requirements
- R1: While `rst_n` is low, and from the first clock edge at which `mrst` is sampled high, every output (`out_a`, `out_b`, `out_c`, `out_d`, `out_fb`, `sync_out`) is 0.
- R2: Each `ratio_sel` code maps to divide values (A,B,C). 0:(2,2,2) 1:(4,2,2) 2:(6,2,2) 3:(6,4,4) 4:(8,2,2) 5:(8,6,6) 6:(8,6,2) 7:(8,6,4) 8:(4,4,4) 9:(2,2,4) 10:(2,2,6) 11:(4,4,6) 12:(2,2,8) 13:(6,6,8) 14:(6,8,2) 15:(4,6,8).
- R3: Number the steps after `mrst` falls k = 1, 2, 3 and so on. A divider of value N drives 1 after step k exactly when (k-1) mod N < N/2, which gives a 50% duty cycle for every N including 6. Every output therefore rises on step 1.
- R4: `fb_sel` codes 0..5 give feedback divides of 4, 6, 8, 12, 16 and 32. Codes 6 and 7 give 32. The output follows the waveform rule of R3.
- R5: `sync_out` is 1 after step k exactly when k ≥ 1 and k is a multiple of both the A and C divides. Without bypass it is therefore one fast-clock cycle wide, and it lies just before a step on which A and C rise together.
- R6: `out_d` carries `sync_out` when the captured `d_sync_en` is 1, and a copy of `out_c` when it is 0.
- R7: With the captured `bypass_en` at 1, a step happens only on a rising edge of `test_clk`. The resulting output change is visible within 3 `clk` edges. With no `test_clk` edge, the outputs hold.
- R8: `ratio_sel`, `fb_sel`, `bypass_en` and `d_sync_en` are captured only at edges where `mrst` is high. Changing them at any other time has no effect on the outputs.
- R9: Without bypass, a step happens on every `clk` edge at which `mrst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mrst | input | 1 | Synchronous realign: clears dividers, captures configuration |
| ratio_sel | input | 4 | Bank ratio code (R2) |
| fb_sel | input | 3 | Feedback divide code (R4) |
| bypass_en | input | 1 | Step the dividers from `test_clk` |
| test_clk | input | 1 | Slow stepping clock for bypass mode |
| d_sync_en | input | 1 | Output D carries the sync flag instead of bank C |
| out_a | output | 1 | Bank A clock |
| out_b | output | 1 | Bank B clock |
| out_c | output | 1 | Bank C clock |
| out_d | output | 1 | Auxiliary output: sync flag or bank C copy |
| out_fb | output | 1 | Feedback clock |
| sync_out | output | 1 | A/C coincidence flag |

## Verification
A counter that has slipped by one phase shows up at once as a wrong level on its output. It also moves the `sync_out` pulse away from the common multiple of the A and C divides, and that shows within one least-common-multiple period (at most 24 steps). A wrongly captured configuration gives the wrong period from step 1. A decode error that affects only the half-period shows as a wrong duty cycle within the first N steps. In bypass mode, a missed or doubled step shifts every later sample by one position, so each test-clock pulse is compared against the step count.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

    localparam int NBANK   = 3;
    localparam int NDIV    = NBANK + 1;        // banks plus feedback
    localparam int BANK_CW = 3;                // counter bits for divides up to 8
    localparam int FB_CW   = 5;                // counter bits for divides up to 32
    localparam int BANK_DW = BANK_CW + 1;
    localparam int FB_DW   = FB_CW + 1;

    typedef logic [BANK_DW-1:0] bank_div_t;
    typedef bank_div_t [NBANK-1:0] bank_set_t; // [0]=A [1]=B [2]=C

    typedef struct packed {
        logic [3:0] ratio;
        logic [2:0] fbsel;
        logic       bypass;
        logic       dsel;
    } rcd_cfg_t;

    function automatic bank_set_t pack3(input int a, input int b, input int c);
        bank_set_t s;
        s[0] = bank_div_t'(a);
        s[1] = bank_div_t'(b);
        s[2] = bank_div_t'(c);
        return s;
    endfunction

    function automatic bank_set_t bank_divs(input logic [3:0] code);
        bank_set_t s;
        case (code)
            4'd0:    s = pack3(2, 2, 2);
            4'd1:    s = pack3(4, 2, 2);
            4'd2:    s = pack3(6, 2, 2);
            4'd3:    s = pack3(6, 4, 4);
            4'd4:    s = pack3(8, 2, 2);
            4'd5:    s = pack3(8, 6, 6);
            4'd6:    s = pack3(8, 6, 2);
            4'd7:    s = pack3(8, 6, 4);
            4'd8:    s = pack3(4, 4, 4);
            4'd9:    s = pack3(2, 2, 4);
            4'd10:   s = pack3(2, 2, 6);
            4'd11:   s = pack3(4, 4, 6);
            4'd12:   s = pack3(2, 2, 8);
            4'd13:   s = pack3(6, 6, 8);
            4'd14:   s = pack3(6, 8, 2);
            default: s = pack3(4, 6, 8);
        endcase
        return s;
    endfunction

    function automatic logic [FB_DW-1:0] fb_divide(input logic [2:0] code);
        logic [FB_DW-1:0] v;
        case (code)
            3'd0:    v = FB_DW'(4);
            3'd1:    v = FB_DW'(6);
            3'd2:    v = FB_DW'(8);
            3'd3:    v = FB_DW'(12);
            3'd4:    v = FB_DW'(16);
            default: v = FB_DW'(32);
        endcase
        return v;
    endfunction

endpackage

// File: rtl/rcd_step_gen.sv
module rcd_step_gen #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic test_clk,
    input  logic bypass,
    output logic tick
);
    localparam int SHW = SYNC_STAGES + 1;

    logic [SHW-1:0] sh_d, sh_q;
    logic           rise;

    always_comb begin
        sh_d = {sh_q[SHW-2:0], test_clk};
        rise = sh_q[SHW-2] & ~sh_q[SHW-1];
        tick = bypass ? rise : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/rcd_phase_div.sv
module rcd_phase_div #(
    parameter int CW = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        realign,
    input  logic        tick,
    input  logic [CW:0] div,
    output logic        clk_out,
    output logic        wrap
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          out;
    } div_state_t;

    div_state_t    d, q;
    logic [CW:0]   half;
    logic [CW:0]   cnt_ext;

    always_comb begin
        half    = div >> 1;
        cnt_ext = {1'b0, q.cnt};
        wrap    = (cnt_ext == div - 1'b1);
        d       = q;
        if (realign) begin
            d.cnt = '0;
            d.out = 1'b0;
        end else if (tick) begin
            d.out = (cnt_ext < half);
            d.cnt = wrap ? '0 : q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign clk_out = q.out;
endmodule

// File: rtl/ratio_clk_divider.sv
module ratio_clk_divider
    import rcd_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [NDIV-1:0]   SYNC_MASK   = 4'b0101   // banks A and C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mrst,
    input  logic [3:0] ratio_sel,
    input  logic [2:0] fb_sel,
    input  logic       bypass_en,
    input  logic       test_clk,
    input  logic       d_sync_en,
    output logic       out_a,
    output logic       out_b,
    output logic       out_c,
    output logic       out_d,
    output logic       out_fb,
    output logic       sync_out
);
    typedef struct packed {
        rcd_cfg_t cfg;
        logic     sync;
    } top_state_t;

    top_state_t        d, q;
    rcd_cfg_t          cfg_cur;
    logic              tick;
    bank_set_t         bdiv;
    logic [FB_DW-1:0]  fdiv;
    logic [NDIV-1:0]   wrap;
    logic [NDIV-1:0]   dclk;

    assign cfg_cur = q.cfg;
    assign bdiv    = bank_divs(cfg_cur.ratio);
    assign fdiv    = fb_divide(cfg_cur.fbsel);

    rcd_step_gen #(.SYNC_STAGES(SYNC_STAGES)) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .test_clk (test_clk),
        .bypass   (cfg_cur.bypass),
        .tick     (tick)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        rcd_phase_div #(.CW(BANK_CW)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .realign (mrst),
            .tick    (tick),
            .div     (bdiv[b]),
            .clk_out (dclk[b]),
            .wrap    (wrap[b])
        );
    end

    rcd_phase_div #(.CW(FB_CW)) u_fb (
        .clk     (clk),
        .rst_n   (rst_n),
        .realign (mrst),
        .tick    (tick),
        .div     (fdiv),
        .clk_out (dclk[NBANK]),
        .wrap    (wrap[NBANK])
    );

    always_comb begin
        d = q;
        if (mrst) begin
            d.cfg.ratio  = ratio_sel;
            d.cfg.fbsel  = fb_sel;
            d.cfg.bypass = bypass_en;
            d.cfg.dsel   = d_sync_en;
            d.sync       = 1'b0;
        end else if (tick) begin
            d.sync = &(wrap | ~SYNC_MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_a    = dclk[0];
    assign out_b    = dclk[1];
    assign out_c    = dclk[2];
    assign out_fb   = dclk[NBANK];
    assign sync_out = q.sync;
    assign out_d    = cfg_cur.dsel ? q.sync : dclk[2];
endmodule

// File: rtl/rcd_checker.sv
module rcd_checker
    import rcd_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     mrst,
    input logic     tick,
    input rcd_cfg_t cfg,
    input logic     out_a,
    input logic     out_b,
    input logic     out_c,
    input logic     out_d,
    input logic     out_fb,
    input logic     sync_out
);
    // R1
    realign_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrst |=> !out_a && !out_b && !out_c && !out_d && !out_fb && !sync_out);

    // R3
    common_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mrst && $past(mrst) && !cfg.bypass) |=> out_a && out_b && out_c && out_fb);

    // R5
    sync_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_out && !cfg.bypass && !mrst) |=> !sync_out);

    // R5
    sync_precedes_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_out && !cfg.bypass && !mrst) |=> $rose(out_a) && $rose(out_c));

    // R7
    bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.bypass && !mrst && !tick) |=>
            $stable(out_a) && $stable(out_b) && $stable(out_c) && $stable(out_fb));

    // R8
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mrst |=> $stable(cfg));
endmodule

bind ratio_clk_divider rcd_checker u_rcd_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mrst     (mrst),
    .tick     (tick),
    .cfg      (cfg_cur),
    .out_a    (out_a),
    .out_b    (out_b),
    .out_c    (out_c),
    .out_d    (out_d),
    .out_fb   (out_fb),
    .sync_out (sync_out)
);

// File: tb/tb_ratio_clk_divider.sv
`timescale 1ns/1ps
module tb_ratio_clk_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mrst = 1'b0;
    logic [3:0] ratio_sel = '0;
    logic [2:0] fb_sel = '0;
    logic       bypass_en = 1'b0;
    logic       test_clk = 1'b0;
    logic       d_sync_en = 1'b0;
    logic       out_a, out_b, out_c, out_d, out_fb, sync_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ratio_clk_divider dut (
        .clk(clk), .rst_n(rst_n), .mrst(mrst), .ratio_sel(ratio_sel),
        .fb_sel(fb_sel), .bypass_en(bypass_en), .test_clk(test_clk),
        .d_sync_en(d_sync_en), .out_a(out_a), .out_b(out_b), .out_c(out_c),
        .out_d(out_d), .out_fb(out_fb), .sync_out(sync_out)
    );

    // expected divide table (R2)
    function automatic int bdiv(input int code, input int bank);
        int t[16][3] = '{'{2,2,2},'{4,2,2},'{6,2,2},'{6,4,4},'{8,2,2},'{8,6,6},
                         '{8,6,2},'{8,6,4},'{4,4,4},'{2,2,4},'{2,2,6},'{4,4,6},
                         '{2,2,8},'{6,6,8},'{6,8,2},'{4,6,8}};
        return t[code][bank];
    endfunction

    // expected feedback divide (R4)
    function automatic int fdiv(input int code);
        case (code)
            0: return 4;
            1: return 6;
            2: return 8;
            3: return 12;
            4: return 16;
            default: return 32;
        endcase
    endfunction

    // waveform rule (R3)
    function automatic logic wave(input int k, input int n);
        if (k < 1) return 1'b0;
        return ((k - 1) % n) < (n / 2);
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic check_at(input int k, input int code, input int fcode,
                            input bit dsel, input string req);
        int na = bdiv(code, 0);
        int nb = bdiv(code, 1);
        int nc = bdiv(code, 2);
        logic s = (k >= 1) && (k % na == 0) && (k % nc == 0);
        chk(req, $sformatf("out_a k=%0d code=%0d", k, code), out_a, wave(k, na));
        chk(req, $sformatf("out_b k=%0d code=%0d", k, code), out_b, wave(k, nb));
        chk(req, $sformatf("out_c k=%0d code=%0d", k, code), out_c, wave(k, nc));
        chk("R4", $sformatf("out_fb k=%0d fb=%0d", k, fcode), out_fb, wave(k, fdiv(fcode)));
        chk("R5", $sformatf("sync_out k=%0d code=%0d", k, code), sync_out, s);
        chk("R6", $sformatf("out_d k=%0d dsel=%0b", k, dsel), out_d, dsel ? s : wave(k, nc));
    endtask

    task automatic realign(input int code, input int fcode, input bit byp, input bit dsel);
        @(negedge clk);
        ratio_sel = 4'(code);
        fb_sel    = 3'(fcode);
        bypass_en = byp;
        d_sync_en = dsel;
        mrst      = 1'b1;
        repeat (2) @(negedge clk);
        mrst = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "out_a in rst_n", out_a, 1'b0);
        chk("R1", "out_fb in rst_n", out_fb, 1'b0);
        chk("R1", "sync_out in rst_n", sync_out, 1'b0);
        chk("R1", "out_d in rst_n", out_d, 1'b0);
        rst_n = 1'b1;
        realign(0, 0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        mrst = 1'b1;
        @(negedge clk);
        chk("R1", "out_a in mrst", out_a, 1'b0);
        chk("R1", "out_b in mrst", out_b, 1'b0);
        chk("R1", "out_c in mrst", out_c, 1'b0);
        chk("R1", "out_fb in mrst", out_fb, 1'b0);
        mrst = 1'b0;
    endtask

    // R2 R3 R4 R5 R6 R9: every ratio code, free-running steps
    task automatic t_ratios();
        for (int code = 0; code < 16; code++) begin
            int  fcode = code % 8;
            bit  dsel  = code[0];
            realign(code, fcode, 1'b0, dsel);
            for (int k = 1; k <= 64; k++) begin
                @(posedge clk);
                @(negedge clk);
                check_at(k, code, fcode, dsel, (k == 1) ? "R3" : "R2");
            end
        end
    endtask

    // R7: bypass stepping from test_clk
    task automatic t_bypass();
        realign(7, 1, 1'b1, 1'b1);
        repeat (20) @(negedge clk);
        check_at(0, 7, 1, 1'b1, "R7");
        for (int k = 1; k <= 30; k++) begin
            test_clk = 1'b1;
            repeat (4) @(negedge clk);
            test_clk = 1'b0;
            repeat (4) @(negedge clk);
            check_at(k, 7, 1, 1'b1, "R7");
        end
    endtask

    // R8: inputs changed without realign are ignored
    task automatic t_latch();
        realign(0, 0, 1'b0, 1'b0);
        for (int k = 1; k <= 40; k++) begin
            if (k == 5) begin
                ratio_sel = 4'd5;
                fb_sel    = 3'd5;
                bypass_en = 1'b1;
                d_sync_en = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
            check_at(k, 0, 0, 1'b0, "R8");
        end
    endtask

    initial begin
        t_reset();
        t_ratios();
        t_bypass();
        t_latch();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule